// File: doc/BRIEF.md
# Video DAC Host Register Decoder

This block is the host-facing register file of a true-colour video DAC. The host presents two address lines and two bank-select pins, and the block joins them into a 4-bit select code. It then steers byte reads and byte writes to three directly addressed command registers, a read-only identification/status register, and a fourth command register. The fourth register is reached indirectly through the status address once it has been unlocked.

The block also turns the command bits into the settings that the pixel path needs: the DAC resolution (6 or 8 bits), the pixel depth as a bit count, and a cursor-enable flag. These outputs are registered.

Accesses to select codes that belong to the palette or cursor logic are not served here. For each such access the block gives a one-cycle strobe together with the code and the direction, so that the neighbouring logic can act on it.

Top module: `dacreg_host`

## Requirements
- R1: After synchronous reset, the three direct command registers and the indirect register read back as 0x00. `dac_8bit` is 0, `pixel_bpp` is 8, `cursor_on` is 0 and `rd_valid` is 0.
- R2: The select code is {bank_sel[1], bank_sel[0], host_addr[1], host_addr[0]}. A write to code 6, 8 or 9 stores `wr_data` in command register 0, 1 or 2 respectively. A read of the same code returns that value on `rd_data`, with `rd_valid` high, in the cycle after `rd_en` is sampled.
- R3: `dac_8bit` follows bit 1 of command register 0.
- R4: While bit 7 of command register 0 is clear, a read of code 10 returns the status byte, and a write to code 10 changes no register.
- R5: While bit 7 of command register 0 is set and bits 7:0 of `pal_wr_index` equal 0x01, code 10 reads and writes command register 3. Index bits above bit 7 are ignored.
- R6: While bit 7 of command register 0 is set, a read of code 10 returns the status byte when the index low byte is 0x00. For any other index low byte except 0x01 it returns 0xFF, and a write there is dropped.
- R7: When bit 5 of command register 2 is clear, `pixel_bpp` is 8. Otherwise bits 6:5 of command register 1 select the depth: 0 gives 32, 1 gives 15 or 16, 2 gives 8, and 3 gives 4.
- R8: In the 15/16 case, bit 3 of command register 1 set gives 16 and clear gives 15.
- R9: `cursor_on` is the OR of bits 1:0 of command register 2. Like all mode outputs, it changes at the second rising edge after the write is sampled.
- R10: The status byte is 0x40, 0x60, 0xD0 or 0x20 for `VARIANT` = 0, 1, 2 or 3. No access changes it.
- R11: An access to codes 0 to 5 or 7 pulses `pal_stb`, and an access to codes 11 to 15 pulses `cur_stb`. Either pulse comes one cycle after the access, with `fwd_code` set to the code and `fwd_write` set to the direction. Reads of these codes return 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 2 | Low two bits of the select code |
| bank_sel | input | 2 | Upper two bits of the select code |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| rd_en | input | 1 | Read strobe, one cycle per byte |
| wr_data | input | 8 | Write byte |
| pal_wr_index | input | IDX_W | Palette write index kept by the palette logic |
| rd_data | output | 8 | Read byte, registered |
| rd_valid | output | 1 | High in the cycle after a read |
| pal_stb | output | 1 | Palette-group access pulse |
| cur_stb | output | 1 | Cursor-group access pulse |
| fwd_code | output | 4 | Select code of the forwarded access |
| fwd_write | output | 1 | Forwarded access was a write |
| dac_8bit | output | 1 | 8-bit DAC resolution selected |
| pixel_bpp | output | 6 | Pixel depth in bits |
| cursor_on | output | 1 | Cursor enabled |

## Verification
The assertions assume that the host raises `wr_en` and `rd_en` in separate cycles. They also assume that `pal_wr_index` is held steady across an access to code 10, since the indirect target is resolved from it in the same cycle. The bench drives every access as a single-cycle pulse on one strobe only, changes the index only while the bus is idle, and sweeps all 256 values through each direct command register as well as all 16 select codes.

// File: rtl/dacreg_pkg.sv
package dacreg_pkg;
  localparam int BYTE_W = 8;
  localparam int CODE_W = 4;
  localparam int BPP_W  = 6;

  localparam logic [CODE_W-1:0] SEL_CMD0 = 4'd6;
  localparam logic [CODE_W-1:0] SEL_CMD1 = 4'd8;
  localparam logic [CODE_W-1:0] SEL_CMD2 = 4'd9;
  localparam logic [CODE_W-1:0] SEL_STAT = 4'd10;

  localparam logic [BYTE_W-1:0] IND_STATUS = 8'h00;
  localparam logic [BYTE_W-1:0] IND_CMD3   = 8'h01;
  localparam logic [BYTE_W-1:0] NO_DATA    = 8'hFF;

  localparam logic [15:0] PAL_MASK = 16'b0000_0000_1011_1111;
  localparam logic [15:0] CUR_MASK = 16'b1111_1000_0000_0000;

  typedef struct packed {
    logic cmd0;
    logic cmd1;
    logic cmd2;
    logic stat;
    logic pal;
    logic cur;
  } sel_hit_t;

  function automatic logic [BYTE_W-1:0] status_id(input int variant);
    case (variant)
      1:       return 8'h60;
      2:       return 8'hD0;
      3:       return 8'h20;
      default: return 8'h40;
    endcase
  endfunction

  function automatic logic [BPP_W-1:0] depth_of(input logic [BYTE_W-1:0] c1,
                                                input logic [BYTE_W-1:0] c2);
    if (!c2[5]) return 6'd8;
    case (c1[6:5])
      2'd0:    return 6'd32;
      2'd1:    return c1[3] ? 6'd16 : 6'd15;
      2'd2:    return 6'd8;
      default: return 6'd4;
    endcase
  endfunction
endpackage

// File: rtl/dacreg_decode.sv
module dacreg_decode
  import dacreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        host_addr,
  input  logic [1:0]        bank_sel,
  input  logic              wr_en,
  input  logic              rd_en,
  output sel_hit_t          hit,
  output logic              pal_stb,
  output logic              cur_stb,
  output logic [CODE_W-1:0] fwd_code,
  output logic              fwd_write
);
  localparam int NCODES = 1 << CODE_W;

  logic [CODE_W-1:0] code;
  logic [NCODES-1:0] onehot;
  logic              access;

  assign code   = {bank_sel, host_addr};
  assign access = wr_en | rd_en;

  genvar g;
  generate
    for (g = 0; g < NCODES; g++) begin : g_dec
      assign onehot[g] = (code == CODE_W'(g));
    end
  endgenerate

  always_comb begin
    hit.cmd0 = onehot[SEL_CMD0];
    hit.cmd1 = onehot[SEL_CMD1];
    hit.cmd2 = onehot[SEL_CMD2];
    hit.stat = onehot[SEL_STAT];
    hit.pal  = |(onehot & PAL_MASK);
    hit.cur  = |(onehot & CUR_MASK);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pal_stb   <= 1'b0;
      cur_stb   <= 1'b0;
      fwd_code  <= '0;
      fwd_write <= 1'b0;
    end else begin
      pal_stb <= access & hit.pal;
      cur_stb <= access & hit.cur;
      if (access) begin
        fwd_code  <= code;
        fwd_write <= wr_en;
      end
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(pal_stb && cur_stb)); // R11
  AST_STROBE_ONESHOT: assert property (@(posedge clk) disable iff (rst)
    !access |=> !pal_stb && !cur_stb); // R11
endmodule

// File: rtl/dacreg_cmdfile.sv
module dacreg_cmdfile
  import dacreg_pkg::*;
#(
  parameter int VARIANT = 0,
  parameter int IDX_W   = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  sel_hit_t          hit,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  pal_wr_index,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [BYTE_W-1:0] cmd0,
  output logic [BYTE_W-1:0] cmd1,
  output logic [BYTE_W-1:0] cmd2
);
  localparam logic [BYTE_W-1:0] STATUS = status_id(VARIANT);

  logic [BYTE_W-1:0] cmd3;
  logic [BYTE_W-1:0] idx_lo;
  logic              unlocked;
  logic              ind_cmd3;
  logic              ind_stat;
  logic [BYTE_W-1:0] rd_mux;

  assign idx_lo   = pal_wr_index[BYTE_W-1:0];
  assign unlocked = cmd0[7];
  assign ind_cmd3 = unlocked && (idx_lo == IND_CMD3);
  assign ind_stat = !unlocked || (idx_lo == IND_STATUS);

  always_comb begin
    rd_mux = NO_DATA;
    if (hit.cmd0)      rd_mux = cmd0;
    else if (hit.cmd1) rd_mux = cmd1;
    else if (hit.cmd2) rd_mux = cmd2;
    else if (hit.stat) begin
      if (ind_cmd3)      rd_mux = cmd3;
      else if (ind_stat) rd_mux = STATUS;
      else               rd_mux = NO_DATA;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd0     <= '0;
      cmd1     <= '0;
      cmd2     <= '0;
      cmd3     <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
      if (wr_en) begin
        if (hit.cmd0) cmd0 <= wr_data;
        if (hit.cmd1) cmd1 <= wr_data;
        if (hit.cmd2) cmd2 <= wr_data;
        if (hit.stat && ind_cmd3) cmd3 <= wr_data;
      end
    end
  end

  AST_RD_VALID: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid); // R2
  AST_RD_QUIET: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid); // R2
  AST_CMD3_LOCKED: assert property (@(posedge clk) disable iff (rst)
    wr_en && hit.stat && !unlocked |=> $stable(cmd3)); // R4
  AST_STATUS_READ: assert property (@(posedge clk) disable iff (rst)
    rd_en && hit.stat && !unlocked |=> rd_data == STATUS); // R4
  AST_IND_MISS: assert property (@(posedge clk) disable iff (rst)
    rd_en && hit.stat && unlocked && idx_lo > IND_CMD3 |=> rd_data == NO_DATA); // R6
  AST_FWD_NODATA: assert property (@(posedge clk) disable iff (rst)
    rd_en && (hit.pal || hit.cur) |=> rd_data == NO_DATA); // R11
endmodule

// File: rtl/dacreg_mode.sv
module dacreg_mode
  import dacreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] cmd0,
  input  logic [BYTE_W-1:0] cmd1,
  input  logic [BYTE_W-1:0] cmd2,
  output logic              dac_8bit,
  output logic [BPP_W-1:0]  pixel_bpp,
  output logic              cursor_on
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dac_8bit  <= 1'b0;
      pixel_bpp <= 6'd8;
      cursor_on <= 1'b0;
    end else begin
      dac_8bit  <= cmd0[1];
      pixel_bpp <= depth_of(cmd1, cmd2);
      cursor_on <= |cmd2[1:0];
    end
  end

  AST_BPP_LEGAL: assert property (@(posedge clk) disable iff (rst)
    pixel_bpp inside {6'd4, 6'd8, 6'd15, 6'd16, 6'd32}); // R7
  AST_BPP_DIRECT: assert property (@(posedge clk) disable iff (rst)
    !cmd2[5] && $stable(cmd2) |=> pixel_bpp == 6'd8); // R7
endmodule

// File: rtl/dacreg_host.sv
module dacreg_host
  import dacreg_pkg::*;
#(
  parameter int VARIANT = 0,
  parameter int IDX_W   = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       host_addr,
  input  logic [1:0]       bank_sel,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [7:0]       wr_data,
  input  logic [IDX_W-1:0] pal_wr_index,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             pal_stb,
  output logic             cur_stb,
  output logic [3:0]       fwd_code,
  output logic             fwd_write,
  output logic             dac_8bit,
  output logic [5:0]       pixel_bpp,
  output logic             cursor_on
);
  sel_hit_t          hit;
  logic [BYTE_W-1:0] cmd0, cmd1, cmd2;

  dacreg_decode u_dec (
    .clk(clk), .rst(rst), .host_addr(host_addr), .bank_sel(bank_sel),
    .wr_en(wr_en), .rd_en(rd_en), .hit(hit), .pal_stb(pal_stb),
    .cur_stb(cur_stb), .fwd_code(fwd_code), .fwd_write(fwd_write)
  );

  dacreg_cmdfile #(.VARIANT(VARIANT), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst(rst), .hit(hit), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .pal_wr_index(pal_wr_index), .rd_data(rd_data),
    .rd_valid(rd_valid), .cmd0(cmd0), .cmd1(cmd1), .cmd2(cmd2)
  );

  dacreg_mode u_mode (
    .clk(clk), .rst(rst), .cmd0(cmd0), .cmd1(cmd1), .cmd2(cmd2),
    .dac_8bit(dac_8bit), .pixel_bpp(pixel_bpp), .cursor_on(cursor_on)
  );

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && rd_en)); // R2
endmodule

// File: tb/sim_dacreg_host.sv
module sim_dacreg_host;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W      = 10;
  localparam int WATCHDOG   = 100000;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [1:0]       host_addr = '0;
  logic [1:0]       bank_sel = '0;
  logic             wr_en = 1'b0;
  logic             rd_en = 1'b0;
  logic [7:0]       wr_data = '0;
  logic [IDX_W-1:0] pal_wr_index = '0;
  logic [7:0]       rd_data;
  logic             rd_valid;
  logic             pal_stb, cur_stb, fwd_write, dac_8bit, cursor_on;
  logic [3:0]       fwd_code;
  logic [5:0]       pixel_bpp;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;

  logic [7:0] s_rd;
  logic       s_val, s_pal, s_cur, s_fw;
  logic [3:0] s_code;

  dacreg_host #(.VARIANT(0), .IDX_W(IDX_W)) u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: act=%0d exp<=%0d cycles", cycles, WATCHDOG);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic [3:0] code, input logic wr, input logic [7:0] v);
    @(negedge clk);
    {bank_sel, host_addr} = code;
    wr_data = v; wr_en = wr; rd_en = !wr;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    s_rd = rd_data; s_val = rd_valid; s_pal = pal_stb; s_cur = cur_stb;
    s_fw = fwd_write; s_code = fwd_code;
  endtask

  function automatic int exp_bpp(input int c1, input int c2);
    if (((c2 >> 5) & 1) == 0) return 8;
    case ((c1 >> 5) & 3)
      0: return 32;
      1: return ((c1 >> 3) & 1) ? 16 : 15;
      2: return 8;
      default: return 4;
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 dac_8bit", dac_8bit, 0);
    chk("R1 pixel_bpp", pixel_bpp, 8);
    chk("R1 cursor_on", cursor_on, 0);
    access(4'd6, 0, 0); chk("R1 cmd0", s_rd, 0); chk("R2 rd_valid", s_val, 1);
    access(4'd8, 0, 0); chk("R1 cmd1", s_rd, 0);
    access(4'd9, 0, 0); chk("R1 cmd2", s_rd, 0);

    // status while locked, writes ignored
    access(4'd10, 0, 0); chk("R4 R10 status", s_rd, 8'h40);
    access(4'd10, 1, 8'h5A);
    access(4'd10, 0, 0); chk("R4 status after write", s_rd, 8'h40);
    pal_wr_index = 10'h001;
    access(4'd6, 1, 8'h80);
    access(4'd10, 0, 0); chk("R1 R4 cmd3 untouched", s_rd, 0);

    // indirect cmd3 access
    for (int v = 0; v < 256; v += 37) begin
      access(4'd10, 1, 8'(v));
      access(4'd10, 0, 0); chk("R5 cmd3", s_rd, v);
    end
    pal_wr_index = 10'h301;
    access(4'd10, 1, 8'hC3);
    access(4'd10, 0, 0); chk("R5 upper index ignored", s_rd, 8'hC3);
    pal_wr_index = 10'h000;
    access(4'd10, 0, 0); chk("R6 index 0 status", s_rd, 8'h40);
    for (int i = 2; i < 256; i += 23) begin
      pal_wr_index = IDX_W'(i);
      access(4'd10, 1, 8'h11);
      access(4'd10, 0, 0); chk("R6 unimplemented index", s_rd, 8'hFF);
    end
    pal_wr_index = 10'h001;
    access(4'd10, 0, 0); chk("R6 cmd3 kept", s_rd, 8'hC3);

    // cmd0 sweep
    for (int v = 0; v < 256; v++) begin
      access(4'd6, 1, 8'(v));
      access(4'd6, 0, 0); chk("R2 cmd0", s_rd, v);
      chk("R3 dac_8bit", dac_8bit, (v >> 1) & 1);
    end

    // cmd1 sweep with depth select enabled
    access(4'd9, 1, 8'h20);
    for (int v = 0; v < 256; v++) begin
      access(4'd8, 1, 8'(v));
      access(4'd8, 0, 0); chk("R2 cmd1", s_rd, v);
      chk("R7 R8 pixel_bpp", pixel_bpp, exp_bpp(v, 8'h20));
    end

    // cmd2 sweep with cmd1 fixed
    access(4'd8, 1, 8'h68);
    for (int v = 0; v < 256; v++) begin
      access(4'd9, 1, 8'(v));
      access(4'd9, 0, 0); chk("R2 cmd2", s_rd, v);
      chk("R9 cursor_on", cursor_on, (v & 3) != 0);
      chk("R7 bpp by cmd2", pixel_bpp, exp_bpp(8'h68, v));
    end

    // mode output latency
    access(4'd9, 1, 8'h00);
    @(negedge clk);
    access(4'd9, 1, 8'h02);
    chk("R9 latency before", cursor_on, 0);
    @(negedge clk);
    chk("R9 latency after", cursor_on, 1);

    // forwarded codes
    for (int c = 0; c < 16; c++) begin
      automatic bit is_pal = (c <= 5) || (c == 7);
      automatic bit is_cur = (c >= 11);
      access(4'(c), 0, 0);
      chk("R11 pal_stb rd", s_pal, is_pal);
      chk("R11 cur_stb rd", s_cur, is_cur);
      if (is_pal || is_cur) begin
        chk("R11 fwd_code", s_code, c);
        chk("R11 fwd_write rd", s_fw, 0);
        chk("R11 rd_data", s_rd, 8'hFF);
        access(4'(c), 1, 8'h33);
        chk("R11 fwd_write wr", s_fw, 1);
        chk("R11 strobe wr", s_pal | s_cur, 1);
      end
    end
    @(negedge clk);
    chk("R11 strobe drops", pal_stb | cur_stb, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule